// File: doc/BRIEF.md
# Two-Port RAM with Collision Arbitration

This block is a synchronous memory with two fully independent access ports, left and right. Each port has an enable, an address, a write strobe, write data, registered read data and a busy pin pair. Accesses to different locations never interact. When both ports are enabled on the same address in the same cycle, the block lets one side proceed. It tells the other side it is busy and suppresses that side's write inside the block. Only enables and addresses take part in this decision. A read and a write collide just as two writes do.

A mode input sets the role of the busy pins. With `master_sel` high the block arbitrates and drives both active-low busy outputs. With `master_sel` low it does not arbitrate: its busy outputs stay released (high), and each active-low busy input acts only as a write inhibit for its own port. One arbitrating instance can therefore feed its busy outputs into the busy inputs of any number of non-arbitrating instances that share the address range. Every instance then blocks the same side's write.

The arbiter is a three-state machine. In `ST_FREE` no port owns a contested address. `ST_LEFT_HELD` and `ST_RIGHT_HELD` record which side won an ongoing collision. Transitions: FREE to LEFT_HELD on a collision where both arrive together or the left port was already there; FREE to RIGHT_HELD on a collision where only the right port presented that address in the previous cycle; HELD to the same HELD while the collision continues; HELD to FREE as soon as the collision ends. A port "was already there" when it was enabled on the same address in the previous cycle.

Top module: `twin_port_ram`

## Requirements
- R1: In master mode a busy output (active low) goes low only while both enables are high and the two addresses are equal, and during every such collision exactly one busy output is low.
- R2: When a collision starts with both ports arriving in the same cycle, the right port receives busy and the left port proceeds.
- R3: When one port was enabled on an address in the previous cycle and the other port now arrives on it, the newcomer receives busy; the same side keeps busy for as long as the collision lasts without a break.
- R4: The arbitration outcome does not depend on the write strobes: a read colliding with a write is resolved exactly as a write colliding with a write.
- R5: A write from the port whose busy output is low does not change memory, while the winning port's write is stored.
- R6: In slave mode (`master_sel` = 0) both busy outputs are held high; a port whose busy input is low has all its writes blocked, and with its busy input high it writes normally.
- R7: A read, whether winning or losing arbitration, returns data on its port's read-data output one clock after it is presented; if the other port writes that location in the same cycle, the read returns the contents from before that write.
- R8: Accesses to different addresses on the two ports proceed in the same cycle without affecting each other.
- R9: After reset both read-data outputs are zero, both busy outputs are high and the arbiter is in `ST_FREE`.
- R10: In slave mode, if both ports are permitted and write the same address in the same cycle, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_sel | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs inhibit writes |
| l_ce | input | 1 | Left port enable |
| l_addr | input | AW | Left port address |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_busy_n_o | output | 1 | Left busy, active low (master mode) |
| l_busy_n_i | input | 1 | Left write permit, low inhibits (slave mode) |
| r_ce | input | 1 | Right port enable |
| r_addr | input | AW | Right port address |
| r_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_busy_n_o | output | 1 | Right busy, active low (master mode) |
| r_busy_n_i | input | 1 | Right write permit, low inhibits (slave mode) |

## Verification
The bench drives simultaneous collisions, including a colliding read against a write. A design that looked at the write strobes would release busy for the read case, and one with the wrong tie-break would stall the left port. It also drives a staggered arrival held over several cycles. An arbiter without the owner state would hand the address back to the left port on the second cycle. Read-before-write data on a losing read is checked, as are slave-mode inhibits and same-address double writes. A store that wrote on the busy side, or that ignored the busy inputs, would leave corrupted words that the follow-up reads expose.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;

    typedef enum logic [1:0] {
        ST_FREE       = 2'd0,
        ST_LEFT_HELD  = 2'd1,
        ST_RIGHT_HELD = 2'd2
    } owner_e;

endpackage

// File: rtl/twin_ram_arbiter.sv
module twin_ram_arbiter
    import twin_ram_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce,
    input  logic [AW-1:0] l_addr,
    input  logic          r_ce,
    input  logic [AW-1:0] r_addr,
    output logic          l_lose,
    output logic          r_lose
);

    owner_e        state_q, state_d;
    logic          l_ce_q, r_ce_q;
    logic [AW-1:0] l_addr_q, r_addr_q;
    logic          clash, l_held, r_held;

    assign clash  = l_ce && r_ce && (l_addr == r_addr);
    assign l_held = l_ce_q && (l_addr_q == l_addr);
    assign r_held = r_ce_q && (r_addr_q == r_addr);

    // state register and access history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_FREE;
            l_ce_q   <= 1'b0;
            r_ce_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            state_q  <= state_d;
            l_ce_q   <= l_ce;
            r_ce_q   <= r_ce;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    // next state: ownership of a contested address
    always_comb begin
        state_d = ST_FREE;
        unique case (state_q)
            ST_FREE: begin
                if (clash)
                    state_d = (r_held && !l_held) ? ST_RIGHT_HELD : ST_LEFT_HELD;
            end
            ST_LEFT_HELD: begin
                if (clash)
                    state_d = ST_LEFT_HELD;
            end
            ST_RIGHT_HELD: begin
                if (clash)
                    state_d = ST_RIGHT_HELD;
            end
            default: state_d = ST_FREE;
        endcase
    end

    // outputs: the side that does not own the contested address loses
    always_comb begin
        l_lose = (state_d == ST_RIGHT_HELD);
        r_lose = (state_d == ST_LEFT_HELD);
    end

endmodule

// File: rtl/twin_ram_busy_pin.sv
module twin_ram_busy_pin (
    input  logic master_sel,
    input  logic lose,
    input  logic busy_n_i,
    input  logic ce,
    input  logic we,
    output logic busy_n_o,
    output logic wr_ok
);

    logic permit;

    assign busy_n_o = master_sel ? ~lose : 1'b1;
    assign permit   = master_sel ? ~lose : busy_n_i;
    assign wr_ok    = ce & we & permit;

endmodule

// File: rtl/twin_ram_store.sv
module twin_ram_store #(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // port a is written last so it wins a same-address double write
    always_ff @(posedge clk) begin
        if (b_wr) mem[b_addr] <= b_wdata;
        if (a_wr) mem[a_addr] <= a_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_rd) a_rdata <= mem[a_addr];
            if (b_rd) b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_sel,
    input  logic          l_ce,
    input  logic [AW-1:0] l_addr,
    input  logic          l_we,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_busy_n_o,
    input  logic          l_busy_n_i,
    input  logic          r_ce,
    input  logic [AW-1:0] r_addr,
    input  logic          r_we,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_busy_n_o,
    input  logic          r_busy_n_i
);

    localparam int SIDES = 2;

    logic [SIDES-1:0] ce_v, we_v, lose_v, bin_v, bout_v, wr_ok_v;
    logic             l_wr_ok, r_wr_ok;

    assign ce_v  = {r_ce, l_ce};
    assign we_v  = {r_we, l_we};
    assign bin_v = {r_busy_n_i, l_busy_n_i};

    twin_ram_arbiter #(.AW(AW)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_ce   (l_ce),
        .l_addr (l_addr),
        .r_ce   (r_ce),
        .r_addr (r_addr),
        .l_lose (lose_v[0]),
        .r_lose (lose_v[1])
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        twin_ram_busy_pin u_pin (
            .master_sel (master_sel),
            .lose       (lose_v[s]),
            .busy_n_i   (bin_v[s]),
            .ce         (ce_v[s]),
            .we         (we_v[s]),
            .busy_n_o   (bout_v[s]),
            .wr_ok      (wr_ok_v[s])
        );
    end

    assign l_busy_n_o = bout_v[0];
    assign r_busy_n_o = bout_v[1];
    assign l_wr_ok    = wr_ok_v[0];
    assign r_wr_ok    = wr_ok_v[1];

    twin_ram_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_wr    (l_wr_ok),
        .a_rd    (l_ce & ~l_we),
        .a_addr  (l_addr),
        .a_wdata (l_wdata),
        .a_rdata (l_rdata),
        .b_wr    (r_wr_ok),
        .b_rd    (r_ce & ~r_we),
        .b_addr  (r_addr),
        .b_wdata (r_wdata),
        .b_rdata (r_rdata)
    );

endmodule

// File: rtl/twin_ram_checker.sv
module twin_ram_checker #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_sel,
    input logic          l_ce,
    input logic [AW-1:0] l_addr,
    input logic          r_ce,
    input logic [AW-1:0] r_addr,
    input logic          l_busy_n_o,
    input logic          r_busy_n_o,
    input logic          l_busy_n_i,
    input logic          r_busy_n_i,
    input logic          l_wr_ok,
    input logic          r_wr_ok
);

    logic clash;
    logic past_ok;

    assign clash = l_ce && r_ce && (l_addr == r_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_L_BUSY_NEEDS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !l_busy_n_o) |-> clash); // R1
    AST_R_BUSY_NEEDS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !r_busy_n_o) |-> clash); // R1
    AST_CLASH_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && clash) |-> ($countones({l_busy_n_o, r_busy_n_o}) == 1)); // R1
    AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && master_sel && clash && $past(master_sel && clash))
            |-> (l_busy_n_o == $past(l_busy_n_o))); // R3
    AST_L_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !l_busy_n_o) |-> !l_wr_ok); // R5
    AST_R_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !r_busy_n_o) |-> !r_wr_ok); // R5
    AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (l_busy_n_o && r_busy_n_o)); // R6
    AST_L_SLAVE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !l_busy_n_i) |-> !l_wr_ok); // R6
    AST_R_SLAVE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !r_busy_n_i) |-> !r_wr_ok); // R6

endmodule

bind twin_port_ram twin_ram_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_sel (master_sel),
    .l_ce       (l_ce),
    .l_addr     (l_addr),
    .r_ce       (r_ce),
    .r_addr     (r_addr),
    .l_busy_n_o (l_busy_n_o),
    .r_busy_n_o (r_busy_n_o),
    .l_busy_n_i (l_busy_n_i),
    .r_busy_n_i (r_busy_n_i),
    .l_wr_ok    (l_wr_ok),
    .r_wr_ok    (r_wr_ok)
);

// File: tb/test_twin_port_ram.sv
module test_twin_port_ram;

    localparam int AW = 12;
    localparam int DW = 18;

    typedef struct {
        int            due;
        bit            side;
        logic [DW-1:0] exp;
        int            req;
    } rd_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_sel = 1'b1;
    logic          l_ce = 1'b0, r_ce = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_we = 1'b0, r_we = 1'b0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_busy_n_o, r_busy_n_o;
    logic          l_busy_n_i = 1'b1, r_busy_n_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    bit nxt_master = 1'b1;
    bit nxt_lbin   = 1'b1;
    bit nxt_rbin   = 1'b1;

    rd_item_t      exp_q[$];
    logic [DW-1:0] model [int];

    always #5 clk = ~clk;

    twin_port_ram #(.AW(AW), .DW(DW)) i_twin_port_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_sel (master_sel),
        .l_ce       (l_ce),
        .l_addr     (l_addr),
        .l_we       (l_we),
        .l_wdata    (l_wdata),
        .l_rdata    (l_rdata),
        .l_busy_n_o (l_busy_n_o),
        .l_busy_n_i (l_busy_n_i),
        .r_ce       (r_ce),
        .r_addr     (r_addr),
        .r_we       (r_we),
        .r_wdata    (r_wdata),
        .r_rdata    (r_rdata),
        .r_busy_n_o (r_busy_n_o),
        .r_busy_n_i (r_busy_n_i)
    );

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_rd(input int a);
        return model.exists(a) ? model[a] : '0;
    endfunction

    // driver: one cycle of stimulus, busy checked mid-cycle, reads queued
    task automatic step(input bit lce, input int la, input bit lwe, input int ld,
                        input bit rce, input int ra, input bit rwe, input int rd,
                        input bit exp_lb, input bit exp_rb, input int req);
        bit l_ok, r_ok;
        @(negedge clk);
        master_sel = nxt_master;
        l_busy_n_i = nxt_lbin;
        r_busy_n_i = nxt_rbin;
        l_ce = lce; l_addr = la[AW-1:0]; l_we = lwe; l_wdata = ld[DW-1:0];
        r_ce = rce; r_addr = ra[AW-1:0]; r_we = rwe; r_wdata = rd[DW-1:0];
        #1;
        check(l_busy_n_o == exp_lb, req, "left busy_n", 32'(l_busy_n_o), 32'(exp_lb));
        check(r_busy_n_o == exp_rb, req, "right busy_n", 32'(r_busy_n_o), 32'(exp_rb));
        l_ok = lce && lwe && (nxt_master ? exp_lb : nxt_lbin);
        r_ok = rce && rwe && (nxt_master ? exp_rb : nxt_rbin);
        if (lce && !lwe) exp_q.push_back('{cyc + 1, 1'b0, model_rd(la), req});
        if (rce && !rwe) exp_q.push_back('{cyc + 1, 1'b1, model_rd(ra), req});
        if (r_ok) model[ra] = rd[DW-1:0];
        if (l_ok) model[la] = ld[DW-1:0];
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8);
    endtask

    // monitor: compares registered read data when it is due
    initial begin
        forever begin
            @(posedge clk);
            cyc = cyc + 1;
            #1;
            while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
                rd_item_t it;
                it = exp_q.pop_front();
                if (it.side)
                    check(r_rdata == it.exp, it.req, "right rdata", 32'(r_rdata), 32'(it.exp));
                else
                    check(l_rdata == it.exp, it.req, "left rdata", 32'(l_rdata), 32'(it.exp));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        check(l_rdata == '0, 9, "left rdata after reset", 32'(l_rdata), 0);
        check(r_rdata == '0, 9, "right rdata after reset", 32'(r_rdata), 0);
        check(l_busy_n_o && r_busy_n_o, 9, "busy after reset",
              32'({l_busy_n_o, r_busy_n_o}), 32'h3);

        // R8: independent writes and reads at different addresses
        step(1, 5, 1, 'h0A5A5, 1, 9, 1, 'h15B5B, 1, 1, 8);
        step(1, 9, 0, 0,       1, 5, 0, 0,       1, 1, 8);
        idle();

        // R2 + R5: same-cycle write collision, left wins, right write dropped
        step(1, 20, 1, 'h111, 1, 20, 1, 'h222, 1, 0, 2);
        idle();
        step(1, 20, 0, 0, 0, 0, 0, 0, 1, 1, 5);
        idle();

        // R4: left read vs right write still busies the right port
        step(1, 20, 0, 0, 1, 20, 1, 'h999, 1, 0, 4);
        idle();
        step(0, 0, 0, 0, 1, 20, 0, 0, 1, 1, 4);
        idle();

        // R3: right holds address 30, left arrives later and gets busy
        step(0, 0, 0, 0,      1, 30, 1, 'h333, 1, 1, 3);
        step(1, 30, 1, 'h444, 1, 30, 1, 'h334, 0, 1, 3);
        step(1, 30, 1, 'h445, 1, 30, 0, 0,     0, 1, 3);
        idle();
        step(1, 30, 0, 0, 0, 0, 0, 0, 1, 1, 3);
        idle();

        // R7: losing read returns old contents while the winner writes
        step(1, 20, 1, 'h555, 1, 20, 0, 0, 1, 0, 7);
        idle();
        step(0, 0, 0, 0, 1, 20, 0, 0, 1, 1, 7);
        idle();

        // R6: slave mode, busy inputs inhibit writes, busy outputs released
        step(1, 40, 1, 'h77, 1, 41, 1, 'h88, 1, 1, 6);
        nxt_master = 1'b0;
        nxt_lbin   = 1'b0;
        step(1, 40, 1, 'h1, 1, 41, 1, 'h2, 1, 1, 6);
        nxt_lbin   = 1'b1;
        step(1, 40, 0, 0, 1, 41, 0, 0, 1, 1, 6);
        nxt_rbin   = 1'b0;
        step(0, 0, 0, 0, 1, 40, 1, 'h3, 1, 1, 6);
        nxt_rbin   = 1'b1;
        step(1, 40, 0, 0, 0, 0, 0, 0, 1, 1, 6);

        // R10: slave mode double write to one address, left data kept
        step(1, 50, 1, 'h5A, 1, 50, 1, 'hA5, 1, 1, 10);
        step(1, 50, 0, 0, 1, 50, 0, 0, 1, 1, 10);
        idle();
        idle();
        idle();

        check(exp_q.size() == 0, 7, "pending reads", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule